// File: doc/BRIEF.md
# Disk Boot Loader Sequencer

This block is a small hardware sequencer that brings up a machine from a hard disk without any processor involvement. On a start pulse it becomes the master of an 8-bit I/O port bus that leads to a disk controller. First it selects drive, track, head and sector zero. It then waits for the drive to report ready, sends a home command, and waits for the home to finish. Finally it sends a sector read command and waits for that read to complete.

If the controller reports a read error, the sequencer stops and raises `fail_o`. Otherwise it throws away the first byte of the sector data and copies the following bytes through a memory write port into a 128-byte window at 0xC780..0xC7FF. Only the low address byte advances, and the copy ends when that byte wraps. It then raises `done_o` and presents 0xC780 as the address where execution should begin. Both outcome flags stay set until the next start. Start pulses that arrive while a sequence is running are ignored.

Top module: `disk_boot_seq`

## Requirements
- R1: After reset, `io_req_o`, `mem_we_o`, `done_o` and `fail_o` are 0 and `entry_addr_o` is 0x0000.
- R2: While `io_req_o` is 1 and `io_ack_i` is 0, the next cycle keeps `io_req_o` at 1 and keeps `io_we_o`, `io_addr_o` and `io_wdata_o` unchanged. A transfer completes in the cycle where `io_req_o` and `io_ack_i` are both 1, and `io_rdata_i` is sampled in that cycle.
- R3: A start first performs four writes of 0x00, in this order: port 0xCD (drive), port 0xC9 (track), port 0xCA (head), port 0xCB (sector).
- R4: The sequencer then reads status port 0xC8 repeatedly until bit 6 (ready) is 1. After that it writes 0x06 (home) to port 0xC8.
- R5: After the home command, it reads port 0xC8 until bit 7 (busy) is 0. It then writes 0x01 (read sector) to port 0xC8.
- R6: After the read command, it reads port 0xC8 while bit 7 is 1, and bit 1 is ignored during that time. On the first read with bit 7 at 0, a 1 in bit 1 makes the sequencer raise `fail_o` and issue no further I/O.
- R7: On a successful read, the first read of data port 0xCC produces no memory write.
- R8: The next 128 reads of port 0xCC are each written to memory one cycle after their acknowledge. The addresses run 0xC780, 0xC781, … up to 0xC7FF, and the data is the byte that was read.
- R9: After the last write, `done_o` is 1 and `entry_addr_o` is 0xC780. Whenever `done_o` is 0, `entry_addr_o` is 0x0000.
- R10: `done_o` and `fail_o` are never both 1. Each stays at 1 until a start, and one cycle after a start both are 0. A start pulse during a running sequence changes nothing.
- R11: Once `done_o` or `fail_o` is 1, `io_req_o` stays 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a boot sequence (taken only when not running) |
| io_req_o | output | 1 | I/O transfer request |
| io_we_o | output | 1 | 1 = port write, 0 = port read |
| io_addr_o | output | 8 | I/O port address |
| io_wdata_o | output | 8 | Port write data |
| io_rdata_i | input | 8 | Port read data, valid with acknowledge |
| io_ack_i | input | 1 | Transfer acknowledge |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| done_o | output | 1 | Boot image loaded (sticky) |
| fail_o | output | 1 | Read error reported (sticky) |
| entry_addr_o | output | 16 | Entry address when done |

## Verification
The sequence is tried under four patterns:

- **Zero-latency, no polling.** A controller that acknowledges at once and reports ready and not-busy on the first poll checks the bare order of port accesses and the copy window.
- **Slow acknowledges, long polls.** A controller with two-cycle acknowledge latency and several not-ready and busy polls shows whether requests are held stable. It also shows whether the sequencer tests the correct status bit: not-ready status has busy set, and home-busy status has ready set. A stray start pulse in the middle of this run must leave the access order unchanged.
- **Read error.** A run that ends with an error flag, where the error bit was already set during busy, tells masked polling apart from an early abort.
- **Restart after failure.** A restart after the failed run checks that the flags clear and that the next boot succeeds.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    // Controller port map (fixed by the controller's decode)
    localparam logic [7:0] PORT_STAT  = 8'hC8;  // status read / command write
    localparam logic [7:0] PORT_TRK   = 8'hC9;
    localparam logic [7:0] PORT_HEAD  = 8'hCA;
    localparam logic [7:0] PORT_SECT  = 8'hCB;
    localparam logic [7:0] PORT_DATA  = 8'hCC;
    localparam logic [7:0] PORT_DRIVE = 8'hCD;

    localparam logic [7:0] CMD_HOME = 8'h06;
    localparam logic [7:0] CMD_READ = 8'h01;

    localparam int RDY_BIT  = 6;
    localparam int BUSY_BIT = 7;
    localparam int ERR_BIT  = 1;

    localparam int          NUM_GEO  = 4;
    localparam int          GEO_W    = $clog2(NUM_GEO);
    localparam logic [GEO_W-1:0] GEO_LAST = GEO_W'(NUM_GEO - 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ZERO,
        ST_POLL_RDY,
        ST_HOME,
        ST_POLL_HOME,
        ST_READ,
        ST_POLL_READ,
        ST_DISCARD,
        ST_COPY,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic [GEO_W-1:0] geo_idx;
    } fsm_regs_t;

    // Geometry select order: drive, track, head, sector
    function automatic logic [7:0] geo_port(input logic [GEO_W-1:0] idx);
        logic [7:0] p;
        case (idx)
            2'd0:    p = PORT_DRIVE;
            2'd1:    p = PORT_TRK;
            2'd2:    p = PORT_HEAD;
            default: p = PORT_SECT;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/boot_copy_port.sv
module boot_copy_port
    import boot_seq_pkg::*;
#(
    parameter int              DW        = 8,
    parameter int              MAW       = 16,
    parameter int              LOW_W     = 8,
    parameter logic [MAW-1:0]  BASE_ADDR = 16'hC780
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           beat,
    input  logic [DW-1:0]  data,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           last
);

    localparam int               HI_W    = MAW - LOW_W;
    localparam logic [LOW_W-1:0] LOW_INI = BASE_ADDR[LOW_W-1:0];
    localparam logic [HI_W-1:0]  HI_FIX  = BASE_ADDR[MAW-1:LOW_W];

    typedef struct packed {
        logic [LOW_W-1:0] lo;
        logic             we;
        logic [MAW-1:0]   addr;
        logic [DW-1:0]    wdata;
    } copy_regs_t;

    copy_regs_t d, q;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (clear) begin
            d.lo = LOW_INI;
        end else if (beat) begin
            d.we    = 1'b1;
            d.addr  = {HI_FIX, q.lo};
            d.wdata = data;
            d.lo    = q.lo + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.lo    <= LOW_INI;
            q.we    <= 1'b0;
            q.addr  <= '0;
            q.wdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign last      = &q.lo;

    // R8: every write lands in the fixed page, at or above the base
    a_r8_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[MAW-1:LOW_W] == HI_FIX) && (mem_addr[LOW_W-1:0] >= LOW_INI));

    // R8: a beat produces a write in the following cycle carrying the beat data
    a_r8_beat_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !clear) |=> (mem_we && mem_wdata == $past(data)));

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_seq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IOAW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            io_ack,
    input  logic [DW-1:0]   io_rdata,
    input  logic            copy_last,
    output logic            io_req,
    output logic            io_we,
    output logic [IOAW-1:0] io_addr,
    output logic [DW-1:0]   io_wdata,
    output logic            copy_clear,
    output logic            copy_beat,
    output logic            done,
    output logic            fail
);

    fsm_regs_t d, q;

    always_comb begin
        d          = q;
        io_req     = 1'b0;
        io_we      = 1'b0;
        io_addr    = IOAW'(PORT_STAT);
        io_wdata   = '0;
        copy_clear = 1'b0;
        copy_beat  = 1'b0;
        case (q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    d.state    = ST_ZERO;
                    d.geo_idx  = '0;
                    copy_clear = 1'b1;
                end
            end
            ST_ZERO: begin
                io_req  = 1'b1;
                io_we   = 1'b1;
                io_addr = IOAW'(geo_port(q.geo_idx));
                if (io_ack) begin
                    if (q.geo_idx == GEO_LAST) d.state = ST_POLL_RDY;
                    else d.geo_idx = q.geo_idx + 1'b1;
                end
            end
            ST_POLL_RDY: begin
                io_req = 1'b1;
                if (io_ack && io_rdata[RDY_BIT]) d.state = ST_HOME;
            end
            ST_HOME: begin
                io_req   = 1'b1;
                io_we    = 1'b1;
                io_wdata = DW'(CMD_HOME);
                if (io_ack) d.state = ST_POLL_HOME;
            end
            ST_POLL_HOME: begin
                io_req = 1'b1;
                if (io_ack && !io_rdata[BUSY_BIT]) d.state = ST_READ;
            end
            ST_READ: begin
                io_req   = 1'b1;
                io_we    = 1'b1;
                io_wdata = DW'(CMD_READ);
                if (io_ack) d.state = ST_POLL_READ;
            end
            ST_POLL_READ: begin
                io_req = 1'b1;
                if (io_ack && !io_rdata[BUSY_BIT]) begin
                    if (io_rdata[ERR_BIT]) d.state = ST_FAIL;
                    else d.state = ST_DISCARD;
                end
            end
            ST_DISCARD: begin
                io_req  = 1'b1;
                io_addr = IOAW'(PORT_DATA);
                if (io_ack) d.state = ST_COPY;
            end
            ST_COPY: begin
                io_req  = 1'b1;
                io_addr = IOAW'(PORT_DATA);
                if (io_ack) begin
                    copy_beat = 1'b1;
                    if (copy_last) d.state = ST_DONE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.geo_idx <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = (q.state == ST_DONE);
    assign fail = (q.state == ST_FAIL);

    // R2: an unacknowledged request is held with the same address, data and direction
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> (io_req && $stable(io_addr) && $stable(io_we) && $stable(io_wdata)));

    // R10: outcomes are exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R10: done holds without a start
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10: fail holds without a start
    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R11: no bus activity once finished
    a_r11_quiet_when_finished: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> !io_req);

    // R6: a completed read reporting an error ends in fail
    a_r6_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_POLL_READ && io_ack && !io_rdata[BUSY_BIT] && io_rdata[ERR_BIT]) |=> fail);

endmodule

// File: rtl/disk_boot_seq.sv
module disk_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int              DW        = 8,
    parameter int              IOAW      = 8,
    parameter int              MAW       = 16,
    parameter int              LOW_W     = 8,
    parameter logic [MAW-1:0]  BASE_ADDR = 16'hC780
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            io_req_o,
    output logic            io_we_o,
    output logic [IOAW-1:0] io_addr_o,
    output logic [DW-1:0]   io_wdata_o,
    input  logic [DW-1:0]   io_rdata_i,
    input  logic            io_ack_i,
    output logic            mem_we_o,
    output logic [MAW-1:0]  mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic            done_o,
    output logic            fail_o,
    output logic [MAW-1:0]  entry_addr_o
);

    logic copy_clear;
    logic copy_beat;
    logic copy_last;

    boot_seq_fsm #(
        .DW   (DW),
        .IOAW (IOAW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .io_ack     (io_ack_i),
        .io_rdata   (io_rdata_i),
        .copy_last  (copy_last),
        .io_req     (io_req_o),
        .io_we      (io_we_o),
        .io_addr    (io_addr_o),
        .io_wdata   (io_wdata_o),
        .copy_clear (copy_clear),
        .copy_beat  (copy_beat),
        .done       (done_o),
        .fail       (fail_o)
    );

    boot_copy_port #(
        .DW        (DW),
        .MAW       (MAW),
        .LOW_W     (LOW_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_copy (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (copy_clear),
        .beat      (copy_beat),
        .data      (io_rdata_i),
        .mem_we    (mem_we_o),
        .mem_addr  (mem_addr_o),
        .mem_wdata (mem_wdata_o),
        .last      (copy_last)
    );

    assign entry_addr_o = done_o ? BASE_ADDR : '0;

    // R9: entry address is only presented together with done
    a_r9_entry_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (entry_addr_o == BASE_ADDR));

endmodule

// File: tb/disk_boot_seq_tb.sv
`timescale 1ns/1ps
module disk_boot_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        io_req_o, io_we_o;
    logic [7:0]  io_addr_o, io_wdata_o;
    logic [7:0]  io_rdata_i = 8'h00;
    logic        io_ack_i = 1'b0;
    logic        mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        done_o, fail_o;
    logic [15:0] entry_addr_o;

    always #10 clk = ~clk;

    disk_boot_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .io_req_o     (io_req_o),
        .io_we_o      (io_we_o),
        .io_addr_o    (io_addr_o),
        .io_wdata_o   (io_wdata_o),
        .io_rdata_i   (io_rdata_i),
        .io_ack_i     (io_ack_i),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .done_o       (done_o),
        .fail_o       (fail_o),
        .entry_addr_o (entry_addr_o)
    );

    typedef struct {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
        string      tag;
    } io_item_t;

    io_item_t    exp_io[$];
    logic [23:0] exp_mem[$];
    string       mem_tag[$];

    int n_cmp = 0;
    int n_bad = 0;

    // controller model state
    int       lat, rdy_left, home_left, read_left, phase, didx, wcnt;
    bit       err_flag;
    bit       pend;
    logic [7:0] seed;
    logic [7:0] p_addr, p_wdata;
    logic       p_we;

    function automatic logic [7:0] data_at(input int i);
        return 8'(i * 37) + seed;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Responder and I/O monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            io_ack_i = 1'b0;
            wcnt     = 0;
            pend     = 1'b0;
        end else if (io_req_o) begin
            if (pend) begin
                check(io_addr_o == p_addr && io_we_o == p_we && io_wdata_o == p_wdata,
                      "R2", "request held while waiting", {io_we_o, io_wdata_o, io_addr_o},
                      {p_we, p_wdata, p_addr});
            end
            if (wcnt >= lat) begin
                io_ack_i = 1'b1;
                wcnt     = 0;
                pend     = 1'b0;
                if (exp_io.size() == 0) begin
                    check(1'b0, "R11", "unexpected io access", {io_we_o, io_addr_o}, 0);
                end else begin
                    io_item_t e;
                    e = exp_io.pop_front();
                    check(io_we_o == e.we && io_addr_o == e.addr && (!e.we || io_wdata_o == e.data),
                          e.tag, "io access {we,data,addr}", {io_we_o, io_wdata_o, io_addr_o},
                          {e.we, e.data, e.addr});
                end
                io_rdata_i = 8'h00;
                if (io_we_o && io_addr_o == 8'hC8) begin
                    if (io_wdata_o == 8'h06) phase = 2;
                    if (io_wdata_o == 8'h01) phase = 3;
                end else if (!io_we_o && io_addr_o == 8'hC8) begin
                    if (phase == 2) begin
                        if (home_left > 0) begin home_left--; io_rdata_i = 8'hC0; end
                        else io_rdata_i = 8'h40;
                    end else if (phase == 3) begin
                        if (read_left > 0) begin read_left--; io_rdata_i = 8'hC2; end
                        else io_rdata_i = err_flag ? 8'h42 : 8'h40;
                    end else begin
                        if (rdy_left > 0) begin rdy_left--; io_rdata_i = 8'h80; end
                        else io_rdata_i = 8'h40;
                    end
                end else if (!io_we_o && io_addr_o == 8'hCC) begin
                    io_rdata_i = data_at(didx);
                    didx++;
                end
            end else begin
                io_ack_i = 1'b0;
                wcnt++;
                pend    = 1'b1;
                p_addr  = io_addr_o;
                p_we    = io_we_o;
                p_wdata = io_wdata_o;
            end
        end else begin
            io_ack_i = 1'b0;
            pend     = 1'b0;
        end
    end

    // Memory write monitor
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            if (exp_mem.size() == 0) begin
                check(1'b0, "R7", "unexpected memory write", {mem_addr_o, mem_wdata_o}, 0);
            end else begin
                logic [23:0] m;
                string t;
                m = exp_mem.pop_front();
                t = mem_tag.pop_front();
                check({mem_addr_o, mem_wdata_o} == m, t, "memory write {addr,data}",
                      {mem_addr_o, mem_wdata_o}, m);
            end
        end
    end

    // Driver: fill the scoreboard and run one boot
    task automatic run_boot(input int l, input int r, input int h, input int b,
                            input bit e, input int mid, input logic [7:0] sd);
        logic [7:0] gp [4] = '{8'hCD, 8'hC9, 8'hCA, 8'hCB};
        int cyc;
        lat = l; rdy_left = r; home_left = h; read_left = b; err_flag = e;
        phase = 0; didx = 0; seed = sd;
        for (int g = 0; g < 4; g++) exp_io.push_back('{1'b1, gp[g], 8'h00, "R3"});
        for (int i = 0; i <= r; i++) exp_io.push_back('{1'b0, 8'hC8, 8'h00, "R4"});
        exp_io.push_back('{1'b1, 8'hC8, 8'h06, "R4"});
        for (int i = 0; i <= h; i++) exp_io.push_back('{1'b0, 8'hC8, 8'h00, "R5"});
        exp_io.push_back('{1'b1, 8'hC8, 8'h01, "R5"});
        for (int i = 0; i <= b; i++) exp_io.push_back('{1'b0, 8'hC8, 8'h00, "R6"});
        if (!e) begin
            exp_io.push_back('{1'b0, 8'hCC, 8'h00, "R7"});
            for (int k = 0; k < 128; k++) begin
                exp_io.push_back('{1'b0, 8'hCC, 8'h00, "R8"});
                exp_mem.push_back({16'hC780 + 16'(k), data_at(k + 1)});
                mem_tag.push_back(k == 0 ? "R7" : "R8");
            end
        end
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(!done_o && !fail_o, "R10", "flags cleared by start", {done_o, fail_o}, 0);
        if (mid > 0) begin
            repeat (mid) @(negedge clk);
            start_i = 1'b1;                       // R10: must be ignored
            @(negedge clk); start_i = 1'b0;
        end
        cyc = 0;
        while (!(done_o || fail_o) && cyc < 20000) begin
            @(negedge clk); cyc++;
        end
        check(done_o == !e && fail_o == e, e ? "R6" : "R9", "outcome {done,fail}",
              {done_o, fail_o}, {!e, e});
        check(entry_addr_o == (e ? 16'h0000 : 16'hC780), "R9", "entry address",
              entry_addr_o, e ? 16'h0000 : 16'hC780);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!io_req_o, "R11", "bus idle after finish", io_req_o, 0);
        end
        check(exp_io.size() == 0, "R8", "io accesses left unseen", exp_io.size(), 0);
        check(exp_mem.size() == 0, "R8", "memory writes left unseen", exp_mem.size(), 0);
        check(done_o == !e && fail_o == e, "R10", "outcome sticky", {done_o, fail_o}, {!e, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        lat = 0;
        repeat (4) @(negedge clk);
        check(!io_req_o && !mem_we_o && !done_o && !fail_o && entry_addr_o == 16'h0,
              "R1", "reset state", {io_req_o, mem_we_o, done_o, fail_o, entry_addr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_req_o && !done_o && !fail_o, "R1", "idle after reset",
              {io_req_o, done_o, fail_o}, 0);
        // fast controller, nothing to wait for
        run_boot(0, 0, 0, 0, 1'b0, 0, 8'h11);
        // slow acknowledge, long polls, stray start mid-run
        run_boot(2, 3, 2, 4, 1'b0, 7, 8'h5A);
        // read error, error bit also shown while busy
        run_boot(1, 1, 1, 2, 1'b1, 0, 8'h23);
        // restart after failure
        run_boot(0, 2, 0, 1, 1'b0, 0, 8'hE7);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule